// File: doc/BRIEF.md
# Mixed-Precision Subgroup Selection Controller

This controller chooses which slice of the narrower packed operand feeds a mixed-precision dot-product unit. When the two operands of a multiply-accumulate have different element widths, one 32-bit register carries more elements than the other. Only one group of them is used per instruction. The controller keeps a subgroup index that the datapath uses to slice that wider-count operand. The index steps forward as MACs are issued and wraps back to zero once every group has been used.

Two counters are kept. A reuse counter keeps the same subgroup for a software-programmed number of qualifying MACs. This matches kernels that reuse one loaded operand against several rows of the other. The index counter then advances and wraps at a limit set by the operand format. Software can overwrite the index at any time to select a group by hand, and the same value is returned on a readback port. Only non-stalled MAC decodes under a mixed format move either counter.

Top module: `mpsel_ctrl`

## Requirements
- R1: The counters advance only in a cycle where `dec_valid_i`, `is_mac_i` and a mixed format are all true together. If any of them is false, the index and the reuse progress hold.
- R2: Format codes on `fmt_i` and their wrap limits are as follows. Codes 0–3 are uniform (16, 8, 4, 2 bit) and never advance. Code 4 is 16x8 with a limit of 2. Code 5 is 16x4 with a limit of 4. Code 6 is 16x2 with a limit of 8. Code 7 is 8x4 with a limit of 2. Code 8 is 8x2 with a limit of 4. Code 9 is 4x2 with a limit of 2. Codes 10–15 are treated as uniform.
- R3: When the index has reached limit−1 and the reuse count completes, the next advance sets the index to 0.
- R4: With `reuse_i` = N ≥ 2, the index advances on every Nth qualifying MAC. Stalled or non-MAC cycles do not count towards N.
- R5: With `reuse_i` equal to 0 or 1, every qualifying MAC advances the index.
- R6: A write (`idx_we_i`=1) loads `idx_wdata_i` into the index and clears the reuse counter. If it coincides with an advance, the write wins.
- R7: A cycle in which `fmt_i` differs from its value in the previous cycle clears the index and the reuse counter. This overrides any write or advance in that cycle.
- R8: Reset clears the index and the reuse counter, so `sub_idx_o` reads 0.
- R9: The index is registered. A change caused by inputs sampled at a rising edge appears only after that edge. `csr_idx_o` always equals `sub_idx_o`.
- R10: A written index at or above the current limit returns to 0 on the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dec_valid_i | input | 1 | Decode stage is decoding this cycle (not stalled) |
| is_mac_i | input | 1 | Decoded instruction is a multiply-accumulate |
| fmt_i | input | 4 | Current operand format code |
| reuse_i | input | REUSE_W | MACs per subgroup before the index advances |
| idx_we_i | input | 1 | Software write strobe for the index |
| idx_wdata_i | input | IDX_W | Software write data for the index |
| sub_idx_o | output | IDX_W | Subgroup index driving the operand slicer |
| csr_idx_o | output | IDX_W | Readback copy of the index for the status register |

## Verification
A wrong reuse count does not show at the ports right away. It shows only at the next subgroup boundary, as an index step that comes early or late. That can be up to `reuse_i` qualifying MACs after the fault. A stale format register or a missed clear shows one cycle after the format change, as a non-zero index or a wrong step later. The bench therefore checks the index at each boundary, and also one MAC before it. It also follows every format change and write with a counted MAC sequence, so that hidden reuse progress is brought out at the ports.

// File: rtl/mpsel_pkg.sv
package mpsel_pkg;

    localparam int FMT_W = 4;

    // log2 of element widths of the wide (a) and narrow (b) operand
    typedef struct packed {
        logic [2:0] a_lg;
        logic [2:0] b_lg;
    } fmt_widths_t;

    function automatic fmt_widths_t fmt_widths(input logic [FMT_W-1:0] f);
        fmt_widths_t w;
        case (f)
            4'd0: w = '{a_lg: 3'd4, b_lg: 3'd4};
            4'd1: w = '{a_lg: 3'd3, b_lg: 3'd3};
            4'd2: w = '{a_lg: 3'd2, b_lg: 3'd2};
            4'd3: w = '{a_lg: 3'd1, b_lg: 3'd1};
            4'd4: w = '{a_lg: 3'd4, b_lg: 3'd3};
            4'd5: w = '{a_lg: 3'd4, b_lg: 3'd2};
            4'd6: w = '{a_lg: 3'd4, b_lg: 3'd1};
            4'd7: w = '{a_lg: 3'd3, b_lg: 3'd2};
            4'd8: w = '{a_lg: 3'd3, b_lg: 3'd1};
            4'd9: w = '{a_lg: 3'd2, b_lg: 3'd1};
            default: w = '{a_lg: 3'd3, b_lg: 3'd3};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mpsel_fmt_dec.sv
module mpsel_fmt_dec #(
    parameter int LIM_W = 4
) (
    input  logic [mpsel_pkg::FMT_W-1:0] fmt_i,
    output logic                        mixed_o,
    output logic [LIM_W-1:0]            lim_o
);
    mpsel_pkg::fmt_widths_t w;
    logic [2:0]             diff;

    always_comb begin
        w       = mpsel_pkg::fmt_widths(fmt_i);
        mixed_o = (w.a_lg > w.b_lg);
        diff    = mixed_o ? (w.a_lg - w.b_lg) : 3'd0;
        lim_o   = LIM_W'(1) << diff;
    end
endmodule

// File: rtl/mpsel_wrap_inc.sv
module mpsel_wrap_inc #(
    parameter int W = 3
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W:0]   lim_i,
    output logic [W-1:0] nxt_o
);
    logic [W:0] inc;

    always_comb begin
        inc   = {1'b0, cnt_i} + {{W{1'b0}}, 1'b1};
        nxt_o = (inc >= lim_i) ? '0 : inc[W-1:0];
    end
endmodule

// File: rtl/mpsel_ctrl.sv
module mpsel_ctrl #(
    parameter int IDX_W   = 3,
    parameter int REUSE_W = 8
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        dec_valid_i,
    input  logic                        is_mac_i,
    input  logic [mpsel_pkg::FMT_W-1:0] fmt_i,
    input  logic [REUSE_W-1:0]          reuse_i,
    input  logic                        idx_we_i,
    input  logic [IDX_W-1:0]            idx_wdata_i,
    output logic [IDX_W-1:0]            sub_idx_o,
    output logic [IDX_W-1:0]            csr_idx_o
);
    localparam int LIM_W = IDX_W + 1;

    typedef struct packed {
        logic [IDX_W-1:0]            idx;
        logic [REUSE_W-1:0]          rcnt;
        logic [mpsel_pkg::FMT_W-1:0] fmt;
    } state_t;

    state_t st_d, st_q;

    logic               mixed;
    logic [LIM_W-1:0]   idx_lim;
    logic [REUSE_W-1:0] reuse_eff;
    logic [REUSE_W-1:0] rcnt_nxt;
    logic [IDX_W-1:0]   idx_nxt;
    logic               fmt_chg;
    logic               adv;

    mpsel_fmt_dec #(.LIM_W(LIM_W)) u_dec (
        .fmt_i   (fmt_i),
        .mixed_o (mixed),
        .lim_o   (idx_lim)
    );

    // reuse 0 and 1 both mean "advance on every qualifying MAC"
    assign reuse_eff = (reuse_i <= REUSE_W'(1)) ? REUSE_W'(1) : reuse_i;

    mpsel_wrap_inc #(.W(REUSE_W)) u_rcnt (
        .cnt_i (st_q.rcnt),
        .lim_i ({1'b0, reuse_eff}),
        .nxt_o (rcnt_nxt)
    );

    mpsel_wrap_inc #(.W(IDX_W)) u_idx (
        .cnt_i (st_q.idx),
        .lim_i (idx_lim),
        .nxt_o (idx_nxt)
    );

    always_comb begin
        fmt_chg  = (fmt_i != st_q.fmt);
        adv      = dec_valid_i && is_mac_i && mixed && !fmt_chg;
        st_d     = st_q;
        st_d.fmt = fmt_i;
        if (fmt_chg) begin
            st_d.idx  = '0;
            st_d.rcnt = '0;
        end else if (idx_we_i) begin
            st_d.idx  = idx_wdata_i;
            st_d.rcnt = '0;
        end else if (adv) begin
            st_d.rcnt = rcnt_nxt;
            // reuse counter returning to zero marks the subgroup boundary
            if (rcnt_nxt == '0) begin
                st_d.idx = idx_nxt;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sub_idx_o = st_q.idx;
    assign csr_idx_o = st_q.idx;
endmodule

// File: rtl/mpsel_chk.sv
module mpsel_chk #(
    parameter int IDX_W = 3
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        dec_valid_i,
    input logic                        is_mac_i,
    input logic [mpsel_pkg::FMT_W-1:0] fmt_i,
    input logic                        idx_we_i,
    input logic [IDX_W-1:0]            idx_wdata_i,
    input logic [IDX_W-1:0]            sub_idx_o
);
    // R1: no qualifying MAC, no write, steady format -> index holds
    assert_hold_no_mac_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idx_we_i && !(dec_valid_i && is_mac_i) && $stable(fmt_i))
        |=> $stable(sub_idx_o));

    // R2: uniform or undefined codes never move the index
    assert_uniform_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idx_we_i && $stable(fmt_i) && (fmt_i <= 4'd3 || fmt_i >= 4'd10))
        |=> $stable(sub_idx_o));

    // R3: an advance steps by one or wraps to zero
    assert_step_or_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!idx_we_i && $stable(fmt_i))
        |=> (sub_idx_o == $past(sub_idx_o)
             || sub_idx_o == IDX_W'($past(sub_idx_o) + 1'b1)
             || sub_idx_o == '0));

    // R6: a write with steady format lands next cycle
    assert_write_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idx_we_i && $stable(fmt_i)) |=> (sub_idx_o == $past(idx_wdata_i)));

    // R7: a format change clears the index
    assert_fmt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fmt_i) |=> (sub_idx_o == '0));
endmodule

bind mpsel_ctrl mpsel_chk #(.IDX_W(IDX_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dec_valid_i (dec_valid_i),
    .is_mac_i    (is_mac_i),
    .fmt_i       (fmt_i),
    .idx_we_i    (idx_we_i),
    .idx_wdata_i (idx_wdata_i),
    .sub_idx_o   (sub_idx_o)
);

// File: tb/sim_mpsel_ctrl.sv
`timescale 1ns/1ps
module sim_mpsel_ctrl;
    localparam int IDX_W   = 3;
    localparam int REUSE_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             dv = 1'b0;
    logic             mac = 1'b0;
    logic [3:0]       fmt = 4'd0;
    logic [REUSE_W-1:0] reuse = '0;
    logic             we = 1'b0;
    logic [IDX_W-1:0] wd = '0;
    logic [IDX_W-1:0] idx, csr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    mpsel_ctrl #(.IDX_W(IDX_W), .REUSE_W(REUSE_W)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dv), .is_mac_i(mac),
        .fmt_i(fmt), .reuse_i(reuse), .idx_we_i(we), .idx_wdata_i(wd),
        .sub_idx_o(idx), .csr_idx_o(csr)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drv(input bit d, input bit m, input bit w, input int v);
        dv = d; mac = m; we = w; wd = IDX_W'(v);
    endtask

    // passes through code 15 so the target format always counts as a change
    task automatic set_fmt(input int f);
        drv(0, 0, 0, 0);
        fmt = 4'd15; tick();
        fmt = 4'(f); tick();
    endtask

    task automatic t_reset();
        chk("R8 reset index", idx, 0);
        chk("R9 reset readback", csr, 0);
    endtask

    task automatic t_basic();
        set_fmt(7); reuse = 1;
        drv(1, 1, 0, 0);
        #1 chk("R9 no change before edge", idx, 0);
        tick(); chk("R5 8x4 first advance", idx, 1);
        tick(); chk("R3 8x4 wraps at 2", idx, 0);
        tick(); chk("R2 8x4 again", idx, 1);
        set_fmt(8); reuse = 0;
        drv(1, 1, 0, 0);
        tick(); chk("R5 reuse0 8x2 step1", idx, 1);
        tick(); chk("R5 reuse0 8x2 step2", idx, 2);
        tick(); chk("R2 8x2 step3", idx, 3);
        tick(); chk("R3 8x2 wraps at 4", idx, 0);
        drv(0, 0, 0, 0);
    endtask

    task automatic t_uniform();
        set_fmt(1); reuse = 1;
        drv(1, 1, 0, 0);
        for (int i = 0; i < 4; i++) tick();
        chk("R2 uniform 8 holds", idx, 0);
        set_fmt(12);
        drv(1, 1, 0, 0);
        for (int i = 0; i < 3; i++) tick();
        chk("R2 undefined code holds", idx, 0);
        drv(0, 0, 0, 0);
    endtask

    task automatic t_stall();
        set_fmt(9); reuse = 1;
        drv(0, 1, 0, 0); tick(); chk("R1 stalled MAC holds", idx, 0);
        drv(1, 0, 0, 0); tick(); chk("R1 non-MAC holds", idx, 0);
        drv(1, 1, 0, 0); tick(); chk("R1 qualifying MAC advances", idx, 1);
        drv(0, 0, 0, 0);
    endtask

    task automatic t_reuse();
        set_fmt(6); reuse = 3;
        drv(1, 1, 0, 0); tick(); tick();
        chk("R4 two of three MACs", idx, 0);
        drv(0, 1, 0, 0); tick();
        chk("R4 stall not counted", idx, 0);
        drv(1, 1, 0, 0); tick();
        chk("R4 third MAC advances", idx, 1);
        for (int i = 0; i < 18; i++) tick();
        chk("R2 16x2 reaches 7", idx, 7);
        for (int i = 0; i < 3; i++) tick();
        chk("R3 16x2 wraps at 8", idx, 0);
        drv(0, 0, 0, 0);
    endtask

    task automatic t_write();
        set_fmt(5); reuse = 1;
        drv(0, 0, 1, 2); tick();
        chk("R6 write loads", idx, 2);
        chk("R9 readback matches", csr, 2);
        drv(1, 1, 1, 3); tick();
        chk("R6 write beats advance", idx, 3);
        drv(1, 1, 0, 0); tick();
        chk("R3 16x4 wraps at 4", idx, 0);
        reuse = 2;
        tick(); chk("R4 reuse2 one MAC", idx, 0);
        drv(0, 0, 1, 1); tick();
        chk("R6 write mid-reuse", idx, 1);
        drv(1, 1, 0, 0); tick();
        chk("R6 write cleared reuse count", idx, 1);
        tick(); chk("R4 reuse2 advances", idx, 2);
        drv(0, 0, 0, 0);
    endtask

    task automatic t_fmt();
        set_fmt(8); reuse = 1;
        drv(1, 1, 0, 0); tick(); tick(); tick();
        chk("R2 8x2 at 3", idx, 3);
        fmt = 4'd9; drv(1, 1, 1, 1); tick();
        chk("R7 format change clears over write", idx, 0);
        reuse = 2;
        drv(1, 1, 0, 0); tick();
        chk("R7 partial reuse", idx, 0);
        fmt = 4'd7; drv(0, 0, 0, 0); tick();
        drv(1, 1, 0, 0); tick();
        chk("R7 reuse count cleared by change", idx, 0);
        tick(); chk("R7 counts afresh", idx, 1);
        drv(0, 0, 0, 0);
    endtask

    task automatic t_over();
        set_fmt(7); reuse = 1;
        drv(0, 0, 1, 5); tick();
        chk("R6 out-of-range write loads", idx, 5);
        drv(1, 1, 0, 0); tick();
        chk("R10 out-of-range index wraps", idx, 0);
        drv(0, 0, 1, 6); tick();
        drv(0, 0, 0, 0);
        rst_n = 1'b0; #2;
        chk("R8 reset clears index", idx, 0);
        tick(); rst_n = 1'b1; tick();
        chk("R8 index zero after release", csr, 0);
    endtask

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_uniform();
        t_stall();
        t_reuse();
        t_write();
        t_fmt();
        t_over();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog got 0 expected 1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule